// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial link (a bit clock, a left/right word clock and a data line) and turns each half-frame into a parallel sample. All three link wires are brought into the block's own clock domain through a synchronizer, and a data bit is taken on every rising edge of the bit clock. Each word-clock transition closes a half-frame. The word collected during that half-frame is then sent out on the left or right channel.

A static 3-bit select input chooses the framing and the word length. Right-justified words of 16, 20 or 24 bits, a left-justified 24-bit word and I2S words of 16 or 24 bits are all supported. Every word is delivered as a signed sample aligned to the most significant bit, with a single-cycle strobe for its channel. The two unused select codes raise an error flag and force the delivered samples to zero.

Top module: `sar_rx`

## Requirements
- R1: `fmt_sel` decodes as follows: 3'b000 selects 16-bit right-justified, 3'b010 selects 20-bit right-justified, 3'b100 selects 24-bit right-justified, 3'b110 selects 24-bit left-justified, 3'b001 selects 16-bit I2S and 3'b011 selects 24-bit I2S.
- R2: `sdata` and `lrck` are sampled on rising edges of `bck`. Words are two's complement and are sent most significant bit first.
- R3: In right-justified modes the word is made of the last N bits sampled before the edge at which the new `lrck` level is first seen. Any bits sampled earlier in that half-frame are ignored.
- R4: In left-justified mode the MSB is the bit sampled at the edge where the new `lrck` level is first seen. Bits sampled after the 24th bit are ignored.
- R5: In I2S modes the MSB is the bit sampled one `bck` rising edge after the edge that first shows the new `lrck` level. A half-frame with `lrck` low carries the left channel.
- R6: In the modes that are not I2S, a half-frame with `lrck` high carries the left channel.
- R7: An N-bit word occupies bits [23:24-N] of the sample. The bits below it are zero, so the sign is kept.
- R8: Each completed half-frame gives exactly one single-cycle strobe on `left_valid` or `right_valid`. The two strobes are never high together. Each sample output holds its value until its own next strobe.
- R9: Codes 3'b101 and 3'b111 drive `fmt_err` high, and the strobes that follow carry zero samples. `fmt_err` returns low once a valid code is applied again.
- R10: Reset clears both samples and both strobes. After reset, no word is delivered until a full half-frame has been received between two `lrck` transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the link is oversampled in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck | input | 1 | Serial bit clock |
| lrck | input | 1 | Word clock, one period per stereo frame |
| sdata | input | 1 | Serial audio data |
| fmt_sel | input | 3 | Static framing and word-length select |
| left_sample | output | OUT_W | Last left sample, aligned to the MSB |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_sample | output | OUT_W | Last right sample, aligned to the MSB |
| right_valid | output | 1 | One-cycle strobe for a new right sample |
| fmt_err | output | 1 | A reserved select code is applied |

## Verification
The hardest case to reach from the ports is a select code that changes while the link keeps running. A word-clock level that meant left in one mode means right in the next, and the half-frame that spans the change is decoded under the new code. The stimulus always sends a frame with `lrck` high first and then low, so every frame boundary is a true transition. After each code change it follows the frame under test with a flush frame, and it picks each channel's result by its position among the logged strobes, which depends on whether the code is I2S. Every slot outside the word window is filled with ones, so a window that is one bit off shows up as a corrupted sample.

// File: rtl/sar_pkg.sv
package sar_pkg;

   localparam int unsigned WORD_MAX = 24;

   typedef enum logic [1:0] {
      FR_RIGHT = 2'd0,
      FR_LEFT  = 2'd1,
      FR_I2S   = 2'd2
   } frame_e;

   typedef struct packed {
      frame_e     framing;
      logic [4:0] word_len;
      logic       err;
   } fmt_cfg_t;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("sar_sync: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[i] <= '0;
         end else begin
            if (i == 0) stg[i] <= d;
            else        stg[i] <= stg[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/sar_fmt_dec.sv
module sar_fmt_dec
   import sar_pkg::*;
(
   input  logic [2:0] code,
   output fmt_cfg_t   cfg
);

   always_comb begin
      cfg.framing  = FR_RIGHT;
      cfg.word_len = 5'd24;
      cfg.err      = 1'b0;
      case (code)
         3'b000: cfg.word_len = 5'd16;
         3'b010: cfg.word_len = 5'd20;
         3'b100: cfg.word_len = 5'd24;
         3'b110: cfg.framing  = FR_LEFT;
         3'b001: begin
            cfg.framing  = FR_I2S;
            cfg.word_len = 5'd16;
         end
         3'b011: cfg.framing = FR_I2S;
         default: cfg.err = 1'b1;
      endcase
   end

endmodule

// File: rtl/sar_deser.sv
module sar_deser
   import sar_pkg::*;
#(
   parameter int OUT_W = 24,
   parameter int POS_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             lr_bit,
   input  logic             sd_bit,
   input  frame_e           framing,
   input  logic [4:0]       word_len,
   output logic             word_stb,
   output logic             word_lr,
   output logic [OUT_W-1:0] word_data
);

   logic             seen_q, armed_q, lr_q;
   logic [POS_W-1:0] pos_q;
   logic [OUT_W-1:0] sr_q, acc_q;

   logic             lr_edge, in_win;
   logic [POS_W-1:0] cur_pos, start_p, len_p, rel;
   logic [OUT_W-1:0] acc_nxt, rj_word, done_word;

   always_comb begin
      lr_edge = seen_q && (lr_bit != lr_q);
      cur_pos = lr_edge ? '0 : pos_q;
      start_p = (framing == FR_I2S) ? POS_W'(1) : '0;
      len_p   = POS_W'(word_len);
      rel     = cur_pos - start_p;
      in_win  = (cur_pos >= start_p) && (rel < len_p);
      acc_nxt = lr_edge ? '0 : acc_q;
      if (in_win) acc_nxt[OUT_W-1-int'(rel)] = sd_bit;
      rj_word   = sr_q << (OUT_W - int'(word_len));
      done_word = (framing == FR_RIGHT) ? rj_word : acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q    <= 1'b0;
         armed_q   <= 1'b0;
         lr_q      <= 1'b0;
         pos_q     <= '0;
         sr_q      <= '0;
         acc_q     <= '0;
         word_stb  <= 1'b0;
         word_lr   <= 1'b0;
         word_data <= '0;
      end else begin
         word_stb <= 1'b0;
         if (bit_stb) begin
            seen_q <= 1'b1;
            lr_q   <= lr_bit;
            sr_q   <= {sr_q[OUT_W-2:0], sd_bit};
            acc_q  <= acc_nxt;
            pos_q  <= (&cur_pos) ? cur_pos : cur_pos + 1'b1;
            if (lr_edge) begin
               armed_q <= 1'b1;
               if (armed_q) begin
                  word_stb  <= 1'b1;
                  word_lr   <= lr_q;
                  word_data <= done_word;
               end
            end
         end
      end
   end

endmodule

// File: rtl/sar_rx.sv
module sar_rx
   import sar_pkg::*;
#(
   parameter int OUT_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter int POS_W       = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bck,
   input  logic             lrck,
   input  logic             sdata,
   input  logic [2:0]       fmt_sel,
   output logic [OUT_W-1:0] left_sample,
   output logic             left_valid,
   output logic [OUT_W-1:0] right_sample,
   output logic             right_valid,
   output logic             fmt_err
);

   localparam int POS_MAX = (1 << POS_W) - 1;

   if (OUT_W < int'(WORD_MAX)) begin : g_bad_width
      $error("sar_rx: OUT_W must hold a 24-bit word");
   end
   if (POS_MAX <= int'(WORD_MAX) + 1) begin : g_bad_pos
      $error("sar_rx: POS_W too small for the word window");
   end

   logic s_bck, s_lr, s_sd, bck_d, bit_stb;

   if (SYNC_STAGES > 0) begin : g_sync
      sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     ({bck, lrck, sdata}),
         .q     ({s_bck, s_lr, s_sd})
      );
   end else begin : g_direct
      assign {s_bck, s_lr, s_sd} = {bck, lrck, sdata};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bck_d <= 1'b0;
      else        bck_d <= s_bck;
   end
   assign bit_stb = s_bck & ~bck_d;

   fmt_cfg_t cfg;

   sar_fmt_dec u_dec (
      .code (fmt_sel),
      .cfg  (cfg)
   );

   logic             w_stb, w_lr, is_left;
   logic [OUT_W-1:0] w_data;

   sar_deser #(.OUT_W(OUT_W), .POS_W(POS_W)) u_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_stb   (bit_stb),
      .lr_bit    (s_lr),
      .sd_bit    (s_sd),
      .framing   (cfg.framing),
      .word_len  (cfg.word_len),
      .word_stb  (w_stb),
      .word_lr   (w_lr),
      .word_data (w_data)
   );

   assign is_left = (cfg.framing == FR_I2S) ? ~w_lr : w_lr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_sample  <= '0;
         right_sample <= '0;
         left_valid   <= 1'b0;
         right_valid  <= 1'b0;
         fmt_err      <= 1'b0;
      end else begin
         fmt_err     <= cfg.err;
         left_valid  <= 1'b0;
         right_valid <= 1'b0;
         if (w_stb) begin
            if (is_left) begin
               left_valid  <= 1'b1;
               left_sample <= cfg.err ? '0 : w_data;
            end else begin
               right_valid  <= 1'b1;
               right_sample <= cfg.err ? '0 : w_data;
            end
         end
      end
   end

endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk #(
   parameter int OUT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic [OUT_W-1:0] left_sample,
   input logic             left_valid,
   input logic [OUT_W-1:0] right_sample,
   input logic             right_valid,
   input logic             fmt_err
);

   // R8: never both channels in one cycle
   a_r8_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({left_valid, right_valid}));

   // R8: strobes last one cycle
   a_r8_left_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      left_valid |=> !left_valid);

   a_r8_right_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      right_valid |=> !right_valid);

   // R8: samples hold between strobes
   a_r8_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !left_valid |-> $stable(left_sample));

   a_r8_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !right_valid |-> $stable(right_sample));

   // R9: reserved codes deliver zero samples
   a_r9_left_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (left_valid && fmt_err) |-> (left_sample == '0));

   a_r9_right_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (right_valid && fmt_err) |-> (right_sample == '0));

endmodule

bind sar_rx sar_rx_chk #(.OUT_W(OUT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .left_sample  (left_sample),
   .left_valid   (left_valid),
   .right_sample (right_sample),
   .right_valid  (right_valid),
   .fmt_err      (fmt_err)
);

// File: tb/sim_sar_rx.sv
`timescale 1ns/1ps
module sim_sar_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bck = 1'b0, lrck = 1'b1, sdata = 1'b0;
   logic [2:0]  fmt_sel = 3'b100;
   logic [23:0] left_sample, right_sample;
   logic        left_valid, right_valid, fmt_err;

   always #2.5 clk = ~clk;

   sar_rx u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .bck          (bck),
      .lrck         (lrck),
      .sdata        (sdata),
      .fmt_sel      (fmt_sel),
      .left_sample  (left_sample),
      .left_valid   (left_valid),
      .right_sample (right_sample),
      .right_valid  (right_valid),
      .fmt_err      (fmt_err)
   );

   int checks = 0, fails = 0;
   int lcnt = 0, rcnt = 0, l_wide = 0, r_wide = 0, both = 0;
   bit done = 0;
   logic lv_prev = 0, rv_prev = 0;
   logic [23:0] left_log [256];
   logic [23:0] right_log [256];

   // {code, left word, right word}; a word's bits sit at the top of its field
   localparam logic [50:0] VECS [12] = '{
      {3'b100, 24'h123456, 24'hFEDCBA},
      {3'b000, 24'hA5C3FF, 24'h7F01AA},
      {3'b010, 24'h7FFFF0, 24'h80001F},
      {3'b110, 24'h5A5A5A, 24'h800000},
      {3'b001, 24'hC0DE77, 24'h7FFF00},
      {3'b011, 24'hABCDEF, 24'h000001},
      {3'b101, 24'h111111, 24'h222222},
      {3'b111, 24'hF0F0F0, 24'h0F0F0F},
      {3'b100, 24'h000000, 24'hFFFFFF},
      {3'b110, 24'hFFFFFF, 24'h000001},
      {3'b011, 24'h800000, 24'h7FFFFF},
      {3'b000, 24'hFFFF00, 24'h0001FF}
   };

   always @(negedge clk) begin
      if (rst_n) begin
         if (left_valid) begin
            if (lcnt < 256) left_log[lcnt] = left_sample;
            lcnt++;
         end
         if (right_valid) begin
            if (rcnt < 256) right_log[rcnt] = right_sample;
            rcnt++;
         end
         if (left_valid && lv_prev) l_wide++;
         if (right_valid && rv_prev) r_wide++;
         if (left_valid && right_valid) both++;
         lv_prev = left_valid;
         rv_prev = right_valid;
      end
   end

   function automatic bit is_rsvd(input logic [2:0] f);
      return f[2] && f[0];
   endfunction

   function automatic bit is_i2s(input logic [2:0] f);
      return f[0] && !f[2];
   endfunction

   function automatic int wlen(input logic [2:0] f);
      if (f[0]) return f[1] ? 24 : 16;
      if (f[2:1] == 2'b00) return 16;
      if (f[2:1] == 2'b01) return 20;
      return 24;
   endfunction

   function automatic logic slot_bit(input logic [2:0] f, input logic [23:0] v, input int p);
      int n, first;
      n = wlen(f);
      if (f == 3'b110)   first = 0;
      else if (is_i2s(f)) first = 1;
      else                first = 32 - n;
      if (p >= first && p < first + n) return v[23-(p-first)];
      return 1'b1;
   endfunction

   function automatic logic [23:0] expect_word(input logic [2:0] f, input logic [23:0] v);
      if (is_rsvd(f)) return 24'h0;
      return v & (24'hFFFFFF << (24 - wlen(f)));
   endfunction

   function automatic string tags(input logic [2:0] f);
      if (is_rsvd(f))    return "R9";
      if (f == 3'b110)   return "R1 R2 R4 R6 R7";
      if (is_i2s(f))     return "R1 R2 R5 R7";
      return "R1 R2 R3 R6 R7";
   endfunction

   task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bit_slot(input logic lr, input logic d);
      @(negedge clk);
      bck = 1'b0; lrck = lr; sdata = d;
      repeat (3) @(negedge clk);
      bck = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_frame(input logic [2:0] f, input logic [23:0] lv, input logic [23:0] rv);
      logic [23:0] hi_v, lo_v;
      hi_v = is_i2s(f) ? rv : lv;
      lo_v = is_i2s(f) ? lv : rv;
      for (int p = 0; p < 32; p++) bit_slot(1'b1, slot_bit(f, hi_v, p));
      for (int p = 0; p < 32; p++) bit_slot(1'b0, slot_bit(f, lo_v, p));
   endtask

   task automatic run_vec(input logic [2:0] f, input logic [23:0] lv, input logic [23:0] rv);
      logic [23:0] got_l, got_r;
      fmt_sel = f;
      send_frame(f, lv, rv);
      send_frame(f, 24'h0, 24'h0);
      repeat (8) @(negedge clk);
      if (is_i2s(f)) begin
         got_l = left_log[lcnt-1];
         got_r = right_log[rcnt-2];
      end else begin
         got_l = left_log[lcnt-2];
         got_r = right_log[rcnt-1];
      end
      check({tags(f), " left"},  got_l, expect_word(f, lv));
      check({tags(f), " right"}, got_r, expect_word(f, rv));
      if (is_rsvd(f)) check("R9 flag set", 24'(fmt_err), 24'h1);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [23:0] held;
      repeat (6) @(negedge clk);
      check("R10 reset left sample",  left_sample, 24'h0);
      check("R10 reset right sample", right_sample, 24'h0);
      check("R10 reset strobes", {22'h0, left_valid, right_valid}, 24'h0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check("R10 quiet after reset", 24'(lcnt + rcnt), 24'h0);

      // R10: first half-frame only arms, next transitions deliver
      send_frame(3'b100, 24'h0F0F0F, 24'h333333);
      send_frame(3'b100, 24'h444444, 24'h555555);
      repeat (8) @(negedge clk);
      check("R10 first left count",  24'(lcnt), 24'h1);
      check("R10 first right count", 24'(rcnt), 24'h1);
      check("R10 first right word",  right_log[0], 24'h333333);
      check("R10 first left word",   left_log[0], 24'h444444);

      for (int i = 0; i < 12; i++) begin
         run_vec(VECS[i][50:48], VECS[i][47:24], VECS[i][23:0]);
      end

      // R8: sample holds while the link is idle
      held = left_sample;
      repeat (60) @(negedge clk);
      check("R8 left holds", left_sample, held);

      // R9: flag clears on a valid code
      fmt_sel = 3'b111;
      repeat (4) @(negedge clk);
      check("R9 flag on reserved", 24'(fmt_err), 24'h1);
      fmt_sel = 3'b010;
      repeat (4) @(negedge clk);
      check("R9 flag clears", 24'(fmt_err), 24'h0);

      check("R8 left strobe width",  24'(l_wide), 24'h0);
      check("R8 right strobe width", 24'(r_wide), 24'h0);
      check("R8 strobes exclusive",  24'(both), 24'h0);
      finish_run();
   end

endmodule